// File: doc/BRIEF.md
# Conditional-Move ALU with Write Gate

This block is the single-cycle execute stage of a small memory-to-memory processor. Each operation takes a 4-bit opcode and two 16-bit operands. It returns a 16-bit result and a write condition. The write condition tells the surrounding datapath whether the result should be stored to its destination. There are no flags. For the two conditional-move opcodes, the result is the second operand and the first operand decides whether the write happens. Every other assigned opcode always writes.

The operation set has two conditional moves, wrapping add and subtract, four bitwise operations and three variable shifts. The bitwise set includes an and-not that stands in for NOT. A shift amount outside 0..15 (negative amounts included) clears the word, or fills it with the sign for the arithmetic right shift. The five unassigned codes give a zero result with no write.

Operands are sampled on a rising clock edge when the clock enable is high, and the outputs are registered at that edge.

Top module: `cmov_alu`

## Requirements
- R1: The opcode and operands sampled at a rising edge with `en` high are reflected on `y` and `wr` directly after that edge (one register stage).
- R2: MNZ (opcode 0000) gives `y` = `b`, and `wr` = 1 exactly when any bit of `a` is 1.
- R3: MLZ (opcode 0001) gives `y` = `b`, and `wr` = `a[15]`.
- R4: Opcodes 0010 through 1010 always give `wr` = 1.
- R5: ADD (0010) gives `a + b` and SUB (0011) gives `a - b`, both modulo 2^16 with no overflow indication.
- R6: Opcode 0100 gives `a & b`, 0101 gives `a | b`, 0110 gives `a ^ b` and 0111 gives `a & ~b`.
- R7: With `b` in 0..15, SL (1000) shifts `a` left by `b` and SRL (1001) shifts it right by `b`, both filling with zeros. SRA (1010) shifts right and fills with `a[15]`.
- R8: For SL and SRL, a `b` outside 0..15 gives `y` = 0. Read as unsigned, this is `b` >= 16, which includes every negative value.
- R9: For SRA, a `b` outside 0..15 gives every bit of `y` equal to `a[15]`.
- R10: Opcodes 1011 through 1111 give `y` = 0 and `wr` = 0.
- R11: While `en` is low at a rising edge, `y` and `wr` keep their values.
- R12: While `rst_n` is low, `y` = 0 and `wr` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for the output registers |
| op | input | 4 | Operation code |
| a | input | 16 | First operand, and the condition source for the moves |
| b | input | 16 | Second operand, and the shift amount for the shifts |
| y | output | 16 | Registered result |
| wr | output | 1 | Registered write condition |

## Verification
All sixteen opcodes are swept against a table of corner operands:
- zero, one, the most positive and most negative words, all ones, and alternating patterns;
- every shift amount from -4 to 19.

The shift sweep separates the in-range shifts from the two out-of-range fill rules at both ends of the range. The corner words separate `wr` for the two moves: a negative word sets both conditions, while a positive nonzero word sets only the not-zero one. A pseudo-random run covers carries and borrows across the whole word. Separate hold and reset sequences show that a low `en` freezes both outputs and that reset clears them.

// File: rtl/cmv_pkg.sv
package cmv_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MNZ = 4'b0000,
    OP_MLZ = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0011,
    OP_AND = 4'b0100,
    OP_OR  = 4'b0101,
    OP_XOR = 4'b0110,
    OP_ANT = 4'b0111,
    OP_SL  = 4'b1000,
    OP_SRL = 4'b1001,
    OP_SRA = 4'b1010
  } cmv_op_e;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2,
    UNIT_NONE  = 2'd3
  } cmv_unit_e;

endpackage

// File: rtl/cmv_addsub.sv
module cmv_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum
);
  // One adder serves both: subtract = a + ~b + 1, carry out dropped (wraps).
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = a + b_eff + W'(sub);
  end
endmodule

// File: rtl/cmv_bitwise.sv
module cmv_bitwise #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   sel,
  output logic [W-1:0] y
);
  // sel: 00 and, 01 or, 10 xor, 11 and-not
  always_comb begin
    unique case (sel)
      2'b00:   y = a & b;
      2'b01:   y = a | b;
      2'b10:   y = a ^ b;
      default: y = a & ~b;
    endcase
  end
endmodule

// File: rtl/cmv_shifter.sv
module cmv_shifter #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] amt,
  input  logic         left,
  input  logic         arith,
  output logic [W-1:0] y
);
  localparam int SW = $clog2(W);

  logic [W-1:0]       a_rev;
  logic [W-1:0]       res_rev;
  logic [W-1:0]       src;
  logic [SW:0][W-1:0] st;
  logic               fill;
  logic               in_range;

  // Left shifts reuse the right shifter on a bit-reversed word.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign a_rev[i]   = a[W-1-i];
    assign res_rev[i] = st[SW][W-1-i];
  end

  assign fill     = arith & ~left & a[W-1];
  assign in_range = ~|amt[W-1:SW];
  assign src      = left ? a_rev : a;
  assign st[0]    = src;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign st[k+1] = amt[k] ? {{S{fill}}, st[k][W-1:S]} : st[k];
  end

  always_comb begin
    if (!in_range)
      y = {W{fill}};
    else if (left)
      y = res_rev;
    else
      y = st[SW];
  end
endmodule

// File: rtl/cmv_cond.sv
module cmv_cond #(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  output logic         wen
);
  import cmv_pkg::*;

  always_comb begin
    case (op)
      OP_MNZ:  wen = |a;
      OP_MLZ:  wen = a[W-1];
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_ANT,
      OP_SL, OP_SRL, OP_SRA:
               wen = 1'b1;
      default: wen = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmov_alu.sv
module cmov_alu #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         wr
);
  import cmv_pkg::*;

  logic [W-1:0] arith_y;
  logic [W-1:0] logic_y;
  logic [W-1:0] shift_y;
  logic         cond;
  cmv_unit_e    unit;
  logic [W-1:0] y_d;
  logic         wr_d;
  logic [W-1:0] y_q;
  logic         wr_q;

  cmv_addsub #(.W(W)) u_addsub (
    .a(a), .b(b), .sub(op[0]), .sum(arith_y)
  );

  cmv_bitwise #(.W(W)) u_bitwise (
    .a(a), .b(b), .sel(op[1:0]), .y(logic_y)
  );

  cmv_shifter #(.W(W)) u_shifter (
    .a(a), .amt(b), .left(op == OP_SL), .arith(op == OP_SRA), .y(shift_y)
  );

  cmv_cond #(.W(W)) u_cond (
    .op(op), .a(a), .wen(cond)
  );

  // Next-state: unit select, result mux, then the clock enable.
  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                 unit = UNIT_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_ANT:  unit = UNIT_LOGIC;
      OP_SL, OP_SRL, OP_SRA:          unit = UNIT_SHIFT;
      default:                        unit = UNIT_NONE;
    endcase
  end

  always_comb begin
    y_d  = y_q;
    wr_d = wr_q;
    if (en) begin
      wr_d = cond;
      case (unit)
        UNIT_ARITH: y_d = arith_y;
        UNIT_LOGIC: y_d = logic_y;
        UNIT_SHIFT: y_d = shift_y;
        default:    y_d = (op == OP_MNZ || op == OP_MLZ) ? b : '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q  <= '0;
      wr_q <= 1'b0;
    end else begin
      y_q  <= y_d;
      wr_q <= wr_d;
    end
  end

  assign y  = y_q;
  assign wr = wr_q;
endmodule

// File: rtl/cmov_alu_chk.sv
module cmov_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [3:0]   op,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] y,
  input logic         wr
);
  localparam int SW = $clog2(W);

  a_r2_move_result: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op <= 4'd1) |=> (y == $past(b)));

  a_r2_mnz_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd0) |=> (wr == (|$past(a))));

  a_r3_mlz_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd1) |=> (wr == $past(a[W-1])));

  a_r4_always_write: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op >= 4'd2 && op <= 4'd10) |=> wr);

  a_r5_add_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd2) |=> (y == W'($past(a) + $past(b))));

  a_r8_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == 4'd8 || op == 4'd9) && |b[W-1:SW]) |=> (y == '0));

  a_r9_sra_range: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == 4'd10 && |b[W-1:SW]) |=> (y == {W{$past(a[W-1])}}));

  a_r10_unassigned: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op >= 4'd11) |=> (y == '0 && !wr));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(y) && $stable(wr)));
endmodule

bind cmov_alu cmov_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op),
  .a(a), .b(b), .y(y), .wr(wr)
);

// File: tb/sim_cmov_alu.sv
module sim_cmov_alu;
  logic        clk;
  logic        rst_n;
  logic        en;
  logic [3:0]  op;
  logic [15:0] a;
  logic [15:0] b;
  logic [15:0] y;
  logic        wr;
  int          n_cmp;
  int          n_bad;
  bit          done;

  cmov_alu #(.W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op),
    .a(a), .b(b), .y(y), .wr(wr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] corner(input int i);
    case (i)
      0:  return 16'h0000;
      1:  return 16'h0001;
      2:  return 16'h0002;
      3:  return 16'h7FFF;
      4:  return 16'h8000;
      5:  return 16'hFFFF;
      6:  return 16'h5555;
      7:  return 16'hAAAA;
      8:  return 16'h00FF;
      9:  return 16'hFF00;
      10: return 16'h8001;
      11: return 16'h000F;
      12: return 16'h0010;
      13: return 16'h1234;
      14: return 16'hFFF0;
      default: return 16'hC3A5;
    endcase
  endfunction

  // Reference: {wr, y} from the requirements.
  function automatic logic [16:0] ref_model(input logic [3:0] o, input logic [15:0] x,
                                            input logic [15:0] z);
    int unsigned amt;
    logic [15:0] r;
    logic        w;
    amt = z;
    w = 1'b1;
    r = 16'h0;
    case (o)
      4'd0: begin r = z; w = (x != 0); end
      4'd1: begin r = z; w = x[15]; end
      4'd2: r = 16'((32'(x) + 32'(z)) % 65536);
      4'd3: r = 16'((32'(x) + 65536 - 32'(z)) % 65536);
      4'd4: r = x & z;
      4'd5: r = x | z;
      4'd6: r = x ^ z;
      4'd7: r = x & ~z;
      4'd8: r = (amt > 15) ? 16'h0 : 16'(x << amt);
      4'd9: r = (amt > 15) ? 16'h0 : (x >> amt);
      4'd10: r = (amt > 15) ? {16{x[15]}} : 16'($signed(x) >>> amt);
      default: begin r = 16'h0; w = 1'b0; end
    endcase
    return {w, r};
  endfunction

  function automatic string y_tag(input logic [3:0] o, input logic [15:0] z);
    if (o <= 4'd1) return "R2";
    if (o <= 4'd3) return "R5";
    if (o <= 4'd7) return "R6";
    if (o <= 4'd10) begin
      if (z > 16'd15) return (o == 4'd10) ? "R9" : "R8";
      return "R7";
    end
    return "R10";
  endfunction

  function automatic string w_tag(input logic [3:0] o);
    if (o == 4'd0) return "R2";
    if (o == 4'd1) return "R3";
    if (o <= 4'd10) return "R4";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, capture at the rising edge, check at the next falling edge (R1).
  task automatic run(input logic [3:0] o, input logic [15:0] x, input logic [15:0] z);
    logic [16:0] e;
    @(negedge clk);
    en = 1'b1; op = o; a = x; b = z;
    e = ref_model(o, x, z);
    @(negedge clk);
    check({"R1/", y_tag(o, z)}, y, e[15:0]);
    check({"R1/", w_tag(o)}, {15'h0, wr}, {15'h0, e[16]});
  endtask

  initial begin
    logic [15:0] lf;
    logic [15:0] y_hold;
    logic        w_hold;
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; en = 1'b0; op = 4'd0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    check("R12 y", y, 16'h0);
    check("R12 wr", {15'h0, wr}, 16'h0);
    rst_n = 1'b1;

    // Full opcode sweep over corner operands and shift amounts -4..19.
    for (int o = 0; o < 16; o++)
      for (int ai = 0; ai < 16; ai++)
        for (int bi = 0; bi < 40; bi++)
          run(4'(o), corner(ai), (bi < 16) ? corner(bi) : 16'(bi - 20));

    // Hold while en is low (R11).
    run(4'd2, 16'h1111, 16'h2222);
    y_hold = y; w_hold = wr;
    @(negedge clk);
    en = 1'b0; op = 4'd12; a = 16'hDEAD; b = 16'hBEEF;
    repeat (2) @(negedge clk);
    check("R11 y", y, y_hold);
    check("R11 wr", {15'h0, wr}, {15'h0, w_hold});

    // Pseudo-random operands across all opcodes.
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] ra;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ra = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run(4'(i % 16), ra, (i % 3 == 0) ? {12'h0, lf[3:0]} : lf);
    end

    // Reset clears outputs (R12).
    run(4'd5, 16'hF0F0, 16'h0F0F);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 y after run", y, 16'h0);
    check("R12 wr after run", {15'h0, wr}, 16'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule